// File: doc/BRIEF.md
# Simultaneous-Sample Conversion Sequencer

This block is the digital controller of a four-sampler data-acquisition front end. A host writes a four-bit mode word over a narrow parallel bus, gated by an active-low select and an active-low write strobe. The word picks one of two input banks, how many channels (one to four) each trigger converts, and whether the converter is powered down. After that single write, every rising edge on the active-low start input freezes all four samplers together. A successive-approximation engine then resolves channels 0, 1, 2 and 3 of the chosen bank in turn, up to the programmed count.

Each channel occupies a fixed slot of `SLOT_CYC` clocks. The first few clocks let the held value settle, and one bit trial per `TRIAL_CYC` clocks follows, most significant bit first. The engine drives an offset-binary trial code to the comparator, and a behavioural comparator input stands in for the analog path. The finished code is converted to two's complement and written into a four-entry result store. When the last slot of the sequence ends, the active-low interrupt drops and the samplers go back to tracking. A start edge while a sequence runs is ignored. A start edge while powered down, or during the wake-up wait after a wake write, is dropped and recorded in a sticky flag.

Top module: `simsamp_seq`

## Requirements
- R1: Out of reset the mode word reads 0000 (bank A, one channel), `int_n` is 1, and `samp_hold`, `pwr_down` and `start_dropped` are 0. A trigger with no prior write converts only channel 0 of bank A.
- R2: The mode word commits on the first clock after the end of a write, whichever of `bus_wr_n` or `bus_cs_n` rises first. It is then visible on `cfg_word`. A write strobe pulsed while `bus_cs_n` is high changes nothing.
- R3: A rising edge of `start_n` in the idle state sets `samp_hold`. The block then converts channels in ascending order from 0, with `cur_ch` starting at 0 and `cur_bank` equal to mode bit 2 (0 = bank A, 1 = bank B).
- R4: With mode bits 1:0 equal to n-1, `int_n` falls and `samp_hold` clears on clock edge 48*n counted from the edge that samples the start edge. `int_n` stays high while `samp_hold` is set.
- R5: After a sequence of n channels, store entry i (bits 14*i+13 down to 14*i of `res_flat`) holds the two's-complement code of bank channel i for each i < n. Entries i >= n keep their earlier contents.
- R6: Each slot runs 6 settle clocks, then 14 trials of 3 clocks each, MSB first. `dac_code` is offset binary, and a trial bit is kept when `cmp_hi` is 1. The stored code equals the comparator threshold, so the input values -8192, 8191, 0 and -1 are returned exactly.
- R7: Start edges that arrive while a sequence is running are ignored and do not change its length.
- R8: Bank and channel count are latched at the start edge, so a mode write during a sequence does not alter that sequence but applies to the next one.
- R9: A write with bit 3 set powers the block down at once (`pwr_down` = 1), aborts any running sequence without asserting the interrupt, and causes later start edges to be dropped with `start_dropped` set.
- R10: A write with bit 3 clear while powered down wakes the block in the mode given by bits 2:0. Start edges in the following `WAKE_CYC` (80) clocks are dropped, and after that they are accepted.
- R11: Any committed mode write clears `start_dropped`.
- R12: An accepted start edge sets `int_n` high again on the same edge that sets `samp_hold`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Active-low select for mode writes |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_din | input | 4 | Mode word from the shared bus |
| start_n | input | 1 | Active-low conversion start; the rising edge triggers |
| cmp_hi | input | 1 | Comparator result: input at or above the trial level |
| dac_code | output | RES_W | Offset-binary trial code for the comparator |
| samp_hold | output | 1 | Samplers held, sequence running |
| cur_bank | output | 1 | Bank of the running sequence |
| cur_ch | output | 2 | Channel being converted |
| int_n | output | 1 | Active-low end-of-sequence interrupt |
| pwr_down | output | 1 | Converter powered down |
| start_dropped | output | 1 | Sticky flag for a dropped start edge |
| cfg_word | output | 4 | Current mode word |
| res_flat | output | NUM_CH*RES_W | Result store, entry i at bits 14*i and up |

## Verification
The hardest case to reach from the ports is a start edge that lands inside the wake-up window. It needs a power-down, then a wake write, then a trigger within 80 clocks. The bench reaches it by issuing the trigger straight after the wake write, and then issues a second trigger well after the window to show that triggers are accepted again. Mid-sequence events, such as an extra trigger, a mode rewrite or a power-down, are driven from inside the cycle-counting loop at a fixed slot offset. This places them inside a running sequence without relying on a separate timed process.

// File: rtl/simsamp_pkg.sv
`timescale 1ns/1ps
package simsamp_pkg;
    localparam int MODE_W        = 4;
    localparam int MODE_PD_BIT   = 3;
    localparam int MODE_BANK_BIT = 2;

    typedef logic [MODE_W-1:0] mode_t;

    // last channel index of a sequence (count minus one)
    function automatic logic [1:0] mode_last(input mode_t m);
        return m[1:0];
    endfunction
endpackage

// File: rtl/simsamp_busif.sv
`timescale 1ns/1ps
module simsamp_busif
    import simsamp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bus_cs_n,
    input  logic  bus_wr_n,
    input  mode_t bus_din,
    output logic  commit,
    output mode_t word
);
    typedef struct packed {
        logic  act;
        mode_t hold;
    } bif_t;

    bif_t q, d;
    logic act_now;

    always_comb begin
        act_now = !bus_cs_n && !bus_wr_n;
        d       = q;
        d.act   = act_now;
        if (act_now) d.hold = bus_din;
        // whichever strobe rises first ends the write
        commit  = q.act && !act_now;
        word    = q.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/simsamp_sar.sv
`timescale 1ns/1ps
module simsamp_sar #(
    parameter int RES_W     = 14,
    parameter int SLOT_CYC  = 48,
    parameter int TRIAL_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_go,
    input  logic             abort,
    input  logic             cmp_hi,
    output logic [RES_W-1:0] dac_code,
    output logic             slot_done,
    output logic [RES_W-1:0] result
);
    localparam int SETTLE = SLOT_CYC - RES_W * TRIAL_CYC;
    localparam int CYC_W  = $clog2(SLOT_CYC);
    localparam int T_W    = $clog2(TRIAL_CYC + 1);
    localparam int B_W    = $clog2(RES_W);
    localparam logic [RES_W-1:0] MSB = {1'b1, {(RES_W-1){1'b0}}};

    typedef struct packed {
        logic             act;
        logic [CYC_W-1:0] cyc;
        logic [T_W-1:0]   tcnt;
        logic [B_W-1:0]   bitp;
        logic [RES_W-1:0] acc;
    } sar_t;

    sar_t q, d;
    logic             trial_ph, decide;
    logic [RES_W-1:0] trial_code, kept;

    always_comb begin
        trial_ph   = q.act && (q.cyc >= CYC_W'(SETTLE));
        trial_code = q.acc | (RES_W'(1) << q.bitp);
        decide     = trial_ph && (q.tcnt == T_W'(TRIAL_CYC - 1));
        kept       = cmp_hi ? trial_code : q.acc;
        slot_done  = decide && (q.bitp == '0);
        result     = kept ^ MSB;
        dac_code   = trial_ph ? trial_code : '0;

        d = q;
        if (q.act && q.cyc != CYC_W'(SLOT_CYC - 1)) d.cyc = q.cyc + 1'b1;
        if (trial_ph) d.tcnt = q.tcnt + 1'b1;
        if (decide) begin
            d.tcnt = '0;
            d.acc  = kept;
            if (q.bitp != '0) d.bitp = q.bitp - 1'b1;
            else              d.act  = 1'b0;
        end
        if (slot_go) begin
            d.act  = 1'b1;
            d.cyc  = '0;
            d.tcnt = '0;
            d.bitp = B_W'(RES_W - 1);
            d.acc  = '0;
        end
        if (abort) d.act = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/simsamp_store.sv
`timescale 1ns/1ps
module simsamp_store #(
    parameter int RES_W = 14,
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] idx,
    input  logic [RES_W-1:0]         wdata,
    output logic [DEPTH*RES_W-1:0]   flat
);
    localparam int IDX_W = $clog2(DEPTH);

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [RES_W-1:0] ent_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            ent_q <= '0;
            else if (we && idx == IDX_W'(g))       ent_q <= wdata;
        end
        assign flat[g*RES_W +: RES_W] = ent_q;
    end
endmodule

// File: rtl/simsamp_seq.sv
`timescale 1ns/1ps
module simsamp_seq
    import simsamp_pkg::*;
#(
    parameter int RES_W     = 14,
    parameter int NUM_CH    = 4,
    parameter int SLOT_CYC  = 48,
    parameter int TRIAL_CYC = 3,
    parameter int WAKE_CYC  = 80
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_cs_n,
    input  logic                      bus_wr_n,
    input  logic [3:0]                bus_din,
    input  logic                      start_n,
    input  logic                      cmp_hi,
    output logic [RES_W-1:0]          dac_code,
    output logic                      samp_hold,
    output logic                      cur_bank,
    output logic [1:0]                cur_ch,
    output logic                      int_n,
    output logic                      pwr_down,
    output logic                      start_dropped,
    output logic [3:0]                cfg_word,
    output logic [NUM_CH*RES_W-1:0]   res_flat
);
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int WAKE_W = $clog2(WAKE_CYC + 1);

    typedef struct packed {
        logic              busy;
        logic [CH_W-1:0]   ch;
        logic [CH_W-1:0]   last;
        logic              bank;
        mode_t             cfg;
        logic              pwr;
        logic [WAKE_W-1:0] wake;
        logic              drop;
        logic              int_n;
        logic              start_prev;
    } seq_t;

    seq_t q, d;

    logic             commit;
    mode_t            word;
    logic             slot_go, abort, slot_done, start_edge;
    logic [RES_W-1:0] sar_res;

    simsamp_busif u_busif (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_cs_n(bus_cs_n),
        .bus_wr_n(bus_wr_n),
        .bus_din (bus_din),
        .commit  (commit),
        .word    (word)
    );

    simsamp_sar #(
        .RES_W    (RES_W),
        .SLOT_CYC (SLOT_CYC),
        .TRIAL_CYC(TRIAL_CYC)
    ) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_go  (slot_go),
        .abort    (abort),
        .cmp_hi   (cmp_hi),
        .dac_code (dac_code),
        .slot_done(slot_done),
        .result   (sar_res)
    );

    simsamp_store #(
        .RES_W(RES_W),
        .DEPTH(NUM_CH)
    ) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (q.busy && slot_done),
        .idx  (q.ch),
        .wdata(sar_res),
        .flat (res_flat)
    );

    always_comb begin
        d            = q;
        slot_go      = 1'b0;
        abort        = 1'b0;
        start_edge   = start_n && !q.start_prev;
        d.start_prev = start_n;

        if (q.wake != '0) d.wake = q.wake - 1'b1;

        // slot completion: advance or finish
        if (q.busy && slot_done) begin
            if (q.ch == q.last) begin
                d.busy  = 1'b0;
                d.int_n = 1'b0;
            end else begin
                d.ch    = q.ch + 1'b1;
                slot_go = 1'b1;
            end
        end

        // trigger: ignored while busy, dropped while asleep or waking
        if (start_edge && !q.busy) begin
            if (q.pwr || q.wake != '0) begin
                d.drop = 1'b1;
            end else begin
                d.busy  = 1'b1;
                d.ch    = '0;
                d.last  = CH_W'(mode_last(q.cfg));
                d.bank  = q.cfg[MODE_BANK_BIT];
                d.int_n = 1'b1;
                slot_go = 1'b1;
            end
        end

        if (commit) begin
            d.cfg  = word;
            d.drop = 1'b0;
            if (word[MODE_PD_BIT]) begin
                d.pwr   = 1'b1;
                d.wake  = '0;
                d.busy  = 1'b0;
                slot_go = 1'b0;
                abort   = 1'b1;
            end else if (q.pwr) begin
                d.pwr  = 1'b0;
                d.wake = WAKE_W'(WAKE_CYC);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q            <= '0;
            q.int_n      <= 1'b1;
            q.start_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign samp_hold     = q.busy;
    assign cur_bank      = q.bank;
    assign cur_ch        = 2'(q.ch);
    assign int_n         = q.int_n;
    assign pwr_down      = q.pwr;
    assign start_dropped = q.drop;
    assign cfg_word      = q.cfg;
endmodule

// File: rtl/simsamp_chk.sv
`timescale 1ns/1ps
module simsamp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_cs_n,
    input logic       samp_hold,
    input logic [1:0] cur_ch,
    input logic       int_n,
    input logic       pwr_down,
    input logic [3:0] cfg_word
);
    // R4
    hold_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        samp_hold |-> int_n);

    // R4
    int_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n) |-> ($past(samp_hold) && !samp_hold));

    // R3
    first_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(samp_hold) |-> (cur_ch == 2'd0));

    // R3
    ch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_hold && $past(samp_hold)) |->
            ((cur_ch == $past(cur_ch)) || (cur_ch == 2'($past(cur_ch) + 2'd1))));

    // R9
    pd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> !samp_hold);

    // R2
    cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_cs_n) |=> $stable(cfg_word));
endmodule

bind simsamp_seq simsamp_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_cs_n (bus_cs_n),
    .samp_hold(samp_hold),
    .cur_ch   (cur_ch),
    .int_n    (int_n),
    .pwr_down (pwr_down),
    .cfg_word (cfg_word)
);

// File: tb/simsamp_seq_tb.sv
`timescale 1ns/1ps
module simsamp_seq_tb_top;
    localparam int RW = 14;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_cs_n = 1'b1, bus_wr_n = 1'b1;
    logic [3:0]    bus_din = '0;
    logic          start_n = 1'b1;
    logic          cmp_hi;
    logic [RW-1:0] dac_code;
    logic          samp_hold, cur_bank, int_n, pwr_down, start_dropped;
    logic [1:0]    cur_ch;
    logic [3:0]    cfg_word;
    logic [NC*RW-1:0] res_flat;

    logic signed [RW-1:0] ana [2][4];
    logic [RW-1:0]        exp_st [4];
    int n_chk = 0, n_err = 0;

    always #2 clk = ~clk;

    simsamp_seq dut_i (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
        .bus_din(bus_din), .start_n(start_n), .cmp_hi(cmp_hi),
        .dac_code(dac_code), .samp_hold(samp_hold), .cur_bank(cur_bank),
        .cur_ch(cur_ch), .int_n(int_n), .pwr_down(pwr_down),
        .start_dropped(start_dropped), .cfg_word(cfg_word), .res_flat(res_flat)
    );

    // behavioural comparator: offset-binary trial against signed input
    always_comb cmp_hi = ($signed(dac_code ^ 14'h2000) <= ana[cur_bank][cur_ch]);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_mode(input logic [3:0] w, input bit cs_end);
        @(negedge clk); bus_cs_n = 1'b0; bus_wr_n = 1'b0; bus_din = w;
        @(negedge clk);
        if (cs_end) bus_cs_n = 1'b1; else bus_wr_n = 1'b1;
        @(negedge clk); bus_cs_n = 1'b1; bus_wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start_n = 1'b0;
        @(negedge clk); start_n = 1'b1;
    endtask

    // inj: 0 none, 1 extra start, 2 mode write injw, 3 power-down at k=30
    task automatic run_seq(input int inj, input logic [3:0] injw, input bit exp_bank,
                           output int k);
        pulse_start();
        k = 0;
        while (1) begin
            @(posedge clk); @(negedge clk); k++;
            if (k == 1) begin
                check(samp_hold == 1'b1, "R3 hold", samp_hold, 1);
                check(int_n == 1'b1, "R12 int high", int_n, 1);
                check(cur_ch == 2'd0, "R3 first ch", cur_ch, 0);
                check(cur_bank == exp_bank, "R3 bank", cur_bank, exp_bank);
            end
            if (k == 30 && inj == 1) start_n = 1'b0;
            if (k == 31 && inj == 1) start_n = 1'b1;
            if (k == 30 && inj >= 2) begin bus_cs_n = 1'b0; bus_wr_n = 1'b0; bus_din = injw; end
            if (k == 31 && inj >= 2) bus_wr_n = 1'b1;
            if (k == 32 && inj >= 2) bus_cs_n = 1'b1;
            if (inj == 3 && k == 40) break;
            if (!int_n || k > 400) break;
        end
    endtask

    task automatic verify_store(input string req);
        for (int i = 0; i < 4; i++)
            check(res_flat[i*RW +: RW] == exp_st[i], req,
                  $signed(res_flat[i*RW +: RW]), $signed(exp_st[i]));
    endtask

    task automatic full_seq(input bit bank, input int n, input int inj,
                            input logic [3:0] injw, input string req);
        int k;
        run_seq(inj, injw, bank, k);
        check(k == 48*n + 1, "R4 duration", k, 48*n + 1);
        check(samp_hold == 1'b0, "R4 hold released", samp_hold, 0);
        for (int i = 0; i < n; i++) exp_st[i] = ana[bank][i];
        verify_store(req);
    endtask

    initial begin
        #600000;
        n_err++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int k;
        for (int b = 0; b < 2; b++)
            for (int c = 0; c < 4; c++) ana[b][c] = '0;
        for (int i = 0; i < 4; i++) exp_st[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(int_n == 1'b1, "R1 int_n", int_n, 1);
        check(cfg_word == 4'd0, "R1 mode", cfg_word, 0);
        check(!samp_hold && !pwr_down && !start_dropped, "R1 flags",
              {samp_hold, pwr_down, start_dropped}, 0);
        // R1 default single channel bank A
        ana[0][0] = 14'sd1234; ana[0][1] = -14'sd77;
        full_seq(1'b0, 1, 0, 4'd0, "R1 R5 default");

        // R5 R6 sweep over banks, counts, value patterns
        for (int p = 0; p < 3; p++)
            for (int b = 0; b < 2; b++)
                for (int n = 1; n <= 4; n++) begin
                    write_mode({1'b0, 1'(b), 2'(n - 1)}, ((b + n) % 2) == 1);
                    check(cfg_word == {1'b0, 1'(b), 2'(n - 1)}, "R2 commit",
                          cfg_word, {1'b0, 1'(b), 2'(n - 1)});
                    for (int c = 0; c < 4; c++) begin
                        if (p == 2) begin
                            case (c)
                                0: ana[b][c] = -14'sd8192;
                                1: ana[b][c] = 14'sd8191;
                                2: ana[b][c] = 14'sd0;
                                default: ana[b][c] = -14'sd1;
                            endcase
                        end else begin
                            ana[b][c] = 14'((b*4 + c) * 2345 + p*7777 + n*311 - 8192);
                        end
                    end
                    full_seq(1'(b), n, 0, 4'd0, p == 2 ? "R6 extremes" : "R5 results");
                end

        // R2 strobe with select high is ignored
        @(negedge clk); bus_din = 4'b0011; bus_wr_n = 1'b0;
        @(negedge clk); bus_wr_n = 1'b1;
        repeat (2) @(negedge clk);
        check(cfg_word == 4'b0111, "R2 cs high ignored", cfg_word, 4'b0111);

        // R7 extra start mid-sequence ignored
        write_mode(4'b0001, 1'b0);
        ana[0][0] = 14'sd4000; ana[0][1] = -14'sd4000;
        full_seq(1'b0, 2, 1, 4'd0, "R7 results");

        // R8 mode rewrite mid-sequence applies to the next one
        full_seq(1'b0, 2, 2, 4'b0011, "R8 results");
        check(cfg_word == 4'b0011, "R8 new mode", cfg_word, 4'b0011);
        ana[0][2] = 14'sd17; ana[0][3] = -14'sd5000;
        full_seq(1'b0, 4, 0, 4'd0, "R8 next seq");

        // R9 power-down aborts
        run_seq(3, 4'b1000, 1'b0, k);
        check(samp_hold == 1'b0, "R9 abort hold", samp_hold, 0);
        check(int_n == 1'b1, "R9 no interrupt", int_n, 1);
        check(pwr_down == 1'b1, "R9 pwr_down", pwr_down, 1);
        verify_store("R9 store untouched");
        pulse_start();
        repeat (3) @(negedge clk);
        check(start_dropped == 1'b1, "R9 drop flag", start_dropped, 1);
        check(samp_hold == 1'b0, "R9 no sequence", samp_hold, 0);

        // R10 wake, R11 flag clear
        write_mode(4'b0101, 1'b1);
        check(pwr_down == 1'b0, "R10 awake", pwr_down, 0);
        check(cfg_word == 4'b0101, "R10 mode", cfg_word, 4'b0101);
        check(start_dropped == 1'b0, "R11 flag cleared", start_dropped, 0);
        pulse_start();
        repeat (3) @(negedge clk);
        check(start_dropped == 1'b1, "R10 early start dropped", start_dropped, 1);
        check(samp_hold == 1'b0, "R10 no early sequence", samp_hold, 0);
        repeat (100) @(negedge clk);
        ana[1][0] = 14'sd2222; ana[1][1] = -14'sd3333;
        full_seq(1'b1, 2, 0, 4'd0, "R10 after wake");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule